// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns bytes written on a parallel port into asynchronous serial frames on a single output line. Written bytes wait in a holding stage, which is a small queue or a single register depending on a parameter. A byte moves into the frame shifter only when the shifter has no frame in progress. A programmable 16-bit divisor sets the bit rate. The divisor produces a tick at the input clock rate divided by the divisor, and each serial bit lasts sixteen of these ticks.

The line-control input selects the following framing options:
- word length of five to eight bits;
- one stop bit, or a longer stop period;
- parity on or off, with even or odd sense, or a fixed (stick) value;
- a break condition that holds the line low.

Two status outputs tell a host whether there is room to write. One reports that the holding stage is empty. The other reports that the holding stage and the shifter are both empty.

Top module: `uart_tx_core`

## Requirements
- R1: Every serial bit except a long stop period lasts exactly 16 × `divisor` clock cycles, for `divisor` values 1 to 65535. The start bit begins on the clock edge at which the byte is loaded into the shifter.
- R2: A byte moves from the holding stage to the shifter only when the shifter is idle, or on the clock edge that ends the last stop bit of the current frame. When the shifter is idle, this happens one clock edge after the byte entered the holding stage. Frames queued back to back follow each other with no idle gap.
- R3: A frame starts with a low start bit, followed by the data bits least-significant first. The number of data bits is set by `line_ctrl[1:0]`: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8.
- R4: When `line_ctrl[3]` is 1, a parity bit follows the data bits. The parity is even when `line_ctrl[4]` is 1 and odd when it is 0, counted over the transmitted data bits only.
- R5: When `line_ctrl[5]` and `line_ctrl[3]` are both 1, the parity bit has a fixed value: 1 if `line_ctrl[4]` is 0, and 0 if `line_ctrl[4]` is 1.
- R6: When `line_ctrl[2]` is 0, the frame ends with one stop bit (high, 16 ticks). When it is 1, the stop period is 24 ticks for 5-bit words and 32 ticks for the other word lengths.
- R7: When no frame is in progress and break is off, `txd` is high.
- R8: While `line_ctrl[6]` is 1, `txd` is low. The frame in progress keeps its timing, so the line continues from the current bit position as soon as break is released.
- R9: `hold_empty` is high exactly when the holding stage holds no byte. `all_empty` is high exactly when the holding stage is empty and no frame is in progress. Both are high after reset.
- R10: The holding stage keeps up to `HOLD_DEPTH` bytes (default 4) and sends them in write order. A write that arrives while the stage is full is dropped.
- R11: The word length, parity and stop settings are captured when a byte is loaded into the shifter. Changing them during a frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| divisor | input | 16 | Clocks per 16x tick (1 to 65535) |
| line_ctrl | input | 7 | Framing control: [1:0] length, [2] stop, [3] parity on, [4] even, [5] stick, [6] break |
| wr_en | input | 1 | Write strobe for one byte |
| wr_data | input | 8 | Byte to queue |
| txd | output | 1 | Serial line output, idle high |
| hold_empty | output | 1 | Holding stage empty |
| all_empty | output | 1 | Holding stage and shifter both empty |

## Verification
A wrong tick count or an incorrect sub-bit counter moves a line transition by at least one clock. The per-cycle comparison reports this at the first bit boundary, which is at most 16 × divisor cycles after the frame starts. A corrupted shift register or captured setting shows up as a wrong line level within the bit where it is sent. A wrong holding-stage level shows up at once on `hold_empty`, or as a missing or extra frame once the queue drains. A fault in break gating or stop-period length shows up on `txd` in the same cycle, or at the end of the frame.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  // Field order matches the line-control bit positions (MSB first).
  typedef struct packed {
    logic       brk;
    logic       stick;
    logic       even;
    logic       par_en;
    logic       long_stop;
    logic [1:0] wlen;
  } line_cfg_t;

  // Index of the last data bit: 4..7 for 5..8 bit words.
  function automatic logic [2:0] last_data_idx(input logic [1:0] wlen);
    return {1'b1, wlen};
  endfunction

  // Index of the last 16x tick inside the stop period.
  function automatic logic [4:0] stop_last_tick(input logic [1:0] wlen, input logic long_stop);
    if (!long_stop) return 5'd15;
    else if (wlen == 2'b00) return 5'd23;
    else return 5'd31;
  endfunction

  function automatic logic [7:0] word_mask(input logic [1:0] wlen);
    return 8'hFF >> (3 - wlen);
  endfunction

  function automatic logic parity_value(input logic [7:0] data, input line_cfg_t cfg);
    logic ones;
    ones = ^(data & word_mask(cfg.wlen));
    if (cfg.stick) return ~cfg.even;
    return cfg.even ? ones : ~ones;
  endfunction

  function automatic logic [15:0] tick_limit(input logic [15:0] div);
    return (div == 16'd0) ? 16'd1 : div;
  endfunction

endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  import uart_tx_pkg::*;

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] limit;

  assign limit = DIV_W'(tick_limit(16'(divisor)));
  assign tick  = run && (cnt_q == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run)    cnt_q <= '0;
    else if (tick)    cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  // R1: with a divisor above one, two ticks are never adjacent
  p_tick_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && limit > 1) |=> !tick);

endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int LW = $clog2(DEPTH + 1);

  logic [LW-1:0] level;

  generate
    if (DEPTH == 1) begin : g_single
      logic [W-1:0] data_q;
      logic         valid_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          data_q  <= '0;
          valid_q <= 1'b0;
        end else begin
          if (push && !valid_q) begin
            data_q  <= wdata;
            valid_q <= 1'b1;
          end else if (pop) begin
            valid_q <= 1'b0;
          end
        end
      end
      assign rdata = data_q;
      assign level = LW'(valid_q);
    end else begin : g_ring
      localparam int PW = $clog2(DEPTH);
      logic [W-1:0]  mem [DEPTH];
      logic [PW-1:0] rd_q, wr_q;
      logic [LW-1:0] cnt_q;
      logic          do_push;
      assign do_push = push && (cnt_q != LW'(DEPTH));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rd_q  <= '0;
          wr_q  <= '0;
          cnt_q <= '0;
          for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
          if (do_push) begin
            mem[wr_q] <= wdata;
            wr_q      <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
          end
          if (pop) rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
          cnt_q <= cnt_q + LW'(do_push) - LW'(pop);
        end
      end
      assign rdata = mem[rd_q];
      assign level = cnt_q;
    end
  endgenerate

  assign empty = (level == '0);
  assign full  = (level == LW'(DEPTH));

  // R10: a write into a full stage without a pop leaves the level at capacity
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> full);

  // R10: never pop an empty stage
  p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      load,
  input  logic [7:0] load_data,
  input  line_cfg_t load_cfg,
  output logic      line,
  output logic      busy,
  output logic      frame_end
);

  tx_state_e  state_q;
  logic [7:0] shreg_q;
  logic [2:0] bidx_q;
  logic [2:0] dlast_q;
  logic [4:0] sub_q;
  logic [4:0] stop_last_q;
  logic       par_en_q;
  logic       par_val_q;
  logic       line_q;
  logic [4:0] bit_last;
  logic       bit_done;

  assign bit_last  = (state_q == ST_STOP) ? stop_last_q : 5'd15;
  assign bit_done  = tick && (sub_q == bit_last);
  assign frame_end = (state_q == ST_STOP) && bit_done;
  assign busy      = (state_q != ST_IDLE);
  assign line      = line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      shreg_q     <= '0;
      bidx_q      <= '0;
      dlast_q     <= '0;
      sub_q       <= '0;
      stop_last_q <= 5'd15;
      par_en_q    <= 1'b0;
      par_val_q   <= 1'b0;
      line_q      <= 1'b1;
    end else if (load) begin
      state_q     <= ST_START;
      shreg_q     <= load_data;
      bidx_q      <= '0;
      dlast_q     <= last_data_idx(load_cfg.wlen);
      sub_q       <= '0;
      stop_last_q <= stop_last_tick(load_cfg.wlen, load_cfg.long_stop);
      par_en_q    <= load_cfg.par_en;
      par_val_q   <= parity_value(load_data, load_cfg);
      line_q      <= 1'b0;
    end else if (tick) begin
      if (!bit_done) begin
        sub_q <= sub_q + 1'b1;
      end else begin
        sub_q <= '0;
        unique case (state_q)
          ST_START: begin
            state_q <= ST_DATA;
            line_q  <= shreg_q[0];
            shreg_q <= shreg_q >> 1;
            bidx_q  <= '0;
          end
          ST_DATA: begin
            if (bidx_q == dlast_q) begin
              state_q <= par_en_q ? ST_PAR : ST_STOP;
              line_q  <= par_en_q ? par_val_q : 1'b1;
            end else begin
              bidx_q  <= bidx_q + 1'b1;
              line_q  <= shreg_q[0];
              shreg_q <= shreg_q >> 1;
            end
          end
          ST_PAR: begin
            state_q <= ST_STOP;
            line_q  <= 1'b1;
          end
          ST_STOP: begin
            state_q <= ST_IDLE;
            line_q  <= 1'b1;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R1: the line level only moves at a bit boundary or at a load
  p_line_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && !$past(bit_done) && !$past(load)) |-> $stable(line_q));

  // R2: a load never interrupts a frame before its final stop edge
  p_load_at_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && busy) |-> frame_end);

endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core #(
  parameter int HOLD_DEPTH = 4,
  parameter int DIV_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic [6:0]       line_ctrl,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic             txd,
  output logic             hold_empty,
  output logic             all_empty
);
  import uart_tx_pkg::*;

  line_cfg_t  cfg;
  logic       tick;
  logic       busy;
  logic       frame_end;
  logic       line;
  logic       load;
  logic       h_empty;
  logic       h_full;
  logic [7:0] h_data;

  assign cfg = line_cfg_t'(line_ctrl);

  uart_tx_hold #(.DEPTH(HOLD_DEPTH), .W(8)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (wr_en),
    .wdata (wr_data),
    .pop   (load),
    .rdata (h_data),
    .empty (h_empty),
    .full  (h_full)
  );

  uart_tx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy),
    .divisor (divisor),
    .tick    (tick)
  );

  assign load = (!busy || frame_end) && !h_empty;

  uart_tx_shift u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .load      (load),
    .load_data (h_data),
    .load_cfg  (cfg),
    .line      (line),
    .busy      (busy),
    .frame_end (frame_end)
  );

  assign txd        = line && !cfg.brk;
  assign hold_empty = h_empty;
  assign all_empty  = h_empty && !busy;

  // R2: a load always draws a byte that was waiting
  p_load_needs_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !hold_empty);

  // R3: the cycle after a load the line carries the low start bit
  p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !txd);

  // R7: idle line is mark unless break is on
  p_idle_mark_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cfg.brk) |-> txd);

  // R9: fully idle implies holder empty
  p_status_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    all_empty |-> hold_empty);

  // R10: a full holder is never left full by a load without a write
  p_drain_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (h_full && load && !wr_en) |=> !h_full);

endmodule

// File: tb/uart_tx_core_tb.sv
module uart_tx_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] divisor = 16'd1;
  logic [6:0]  line_ctrl = 7'h03;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        txd, hold_empty, all_empty;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  string tag = "R9";

  uart_tx_core dut_i (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .line_ctrl(line_ctrl),
    .wr_en(wr_en), .wr_data(wr_data), .txd(txd),
    .hold_empty(hold_empty), .all_empty(all_empty)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference: queue of bytes, list of (level, duration) pairs.
  logic [7:0] q[$];
  int  m_busy = 0;
  int  f_lvl[16];
  int  f_dur[16];
  int  f_n = 0;
  int  f_idx = 0;
  int  f_left = 0;
  int  frames = 0;

  task automatic add_bit(input int lvl, input int ticks);
    f_lvl[f_n] = lvl;
    f_dur[f_n] = ticks * ((divisor == 0) ? 1 : int'(divisor));
    f_n++;
  endtask

  task automatic build_frame(input logic [7:0] b);
    int nbits;
    int ones;
    int p;
    nbits = 5 + int'(line_ctrl[1:0]);
    ones = 0;
    f_n = 0;
    add_bit(0, 16);
    for (int i = 0; i < nbits; i++) begin
      add_bit(int'(b[i]), 16);
      ones += int'(b[i]);
    end
    if (line_ctrl[3]) begin
      if (line_ctrl[5]) p = line_ctrl[4] ? 0 : 1;
      else if (line_ctrl[4]) p = ones % 2;
      else p = 1 - (ones % 2);
      add_bit(p, 16);
    end
    if (!line_ctrl[2]) add_bit(1, 16);
    else if (nbits == 5) add_bit(1, 24);
    else add_bit(1, 32);
  endtask

  task automatic check(input string req, input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    int pre;
    int exp_txd;
    cycles++;
    if (!rst_n) begin
      q.delete();
      m_busy = 0;
      f_idx = 0;
      f_left = 0;
    end else begin
      pre = q.size();
      if (m_busy != 0) begin
        f_left--;
        if (f_left == 0) begin
          f_idx++;
          if (f_idx == f_n) m_busy = 0;
          else f_left = f_dur[f_idx];
        end
      end
      if (m_busy == 0 && pre > 0) begin
        build_frame(q.pop_front());
        m_busy = 1;
        f_idx = 0;
        f_left = f_dur[0];
        frames++;
      end
      if (wr_en && pre < DEPTH) q.push_back(wr_data);
    end
    #1;
    if (rst_n) begin
      exp_txd = (m_busy != 0) ? f_lvl[f_idx] : 1;
      if (line_ctrl[6]) exp_txd = 0;
      check(tag, txd, exp_txd[0], "txd");
      if (hold_empty !== (q.size() == 0) || all_empty !== (q.size() == 0 && m_busy == 0)) begin
        check("R9", 1'b0, 1'b1, "status flags vs model");
      end
    end
  end

  always @(posedge clk) begin
    if (cycles >= WATCHDOG) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic drain();
    while (!(all_empty && m_busy == 0 && q.size() == 0)) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R9", hold_empty, 1'b1, "hold_empty in reset");
    check("R7", txd, 1'b1, "txd in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", all_empty, 1'b1, "all_empty after reset");

    // R1 / R3: 8N1 at divisor 3, measure start bit length
    tag = "R1";
    divisor = 16'd3;
    line_ctrl = 7'h03;
    put(8'h01);
    n = 0;
    while (txd) @(negedge clk);
    while (!txd) begin n++; @(negedge clk); end
    check("R1", n == 48, 1'b1, "start bit lasts 48 cycles");
    drain();

    tag = "R3";
    divisor = 16'd1;
    put(8'hA5);
    drain();

    // R4: 7 bits, even parity, divisor 2
    tag = "R4";
    divisor = 16'd2;
    line_ctrl = 7'h1A;
    put(8'h35);
    drain();
    line_ctrl = 7'h0B;
    put(8'h6C);
    drain();

    // R6: 5 bits odd parity with long stop (24 ticks), then 6 bits two stop
    tag = "R6";
    divisor = 16'd1;
    line_ctrl = 7'h0C;
    put(8'h13);
    drain();
    line_ctrl = 7'h05;
    put(8'h2A);
    drain();

    // R5: stick parity both senses
    tag = "R5";
    line_ctrl = 7'h2B;
    put(8'hFF);
    drain();
    line_ctrl = 7'h3B;
    put(8'h00);
    drain();

    // R10 / R2: burst of six writes into a four-deep holder
    tag = "R10";
    line_ctrl = 7'h03;
    n = frames;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = 8'h40 + 8'(i);
    end
    @(negedge clk);
    wr_en = 1'b0;
    check("R9", hold_empty, 1'b0, "hold_empty with queued bytes");
    check("R9", all_empty, 1'b0, "all_empty while sending");
    tag = "R2";
    drain();
    check("R10", (frames - n) == 5, 1'b1, "five frames after overflow");

    // R8: break raised mid-frame, then released
    tag = "R8";
    divisor = 16'd2;
    put(8'h5A);
    repeat (70) @(negedge clk);
    line_ctrl = 7'h43;
    repeat (5) @(negedge clk);
    check("R8", txd, 1'b0, "txd held low by break");
    repeat (60) @(negedge clk);
    line_ctrl = 7'h03;
    drain();

    // R11: framing change during a frame
    tag = "R11";
    divisor = 16'd1;
    line_ctrl = 7'h03;
    put(8'hC3);
    put(8'h81);
    repeat (20) @(negedge clk);
    line_ctrl = 7'h0C;
    drain();
    line_ctrl = 7'h03;

    // R7: idle high after all traffic
    tag = "R7";
    repeat (10) @(negedge clk);
    check("R7", txd, 1'b1, "idle mark");
    check("R9", all_empty, 1'b1, "all_empty at end");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule